// File: doc/BRIEF.md
# Dual-Channel Output-Compare Timer

This block holds a 16-bit up-counter that advances on a prescaled tick taken from the system clock, and two compare channels that watch it. When the counter steps onto a channel's armed compare value, the channel raises its match flag and loads its programmed level into an output latch. When its enable is set, the latch drives the channel pin. When the enable is clear, the pin passes a general-purpose input through. A single interrupt line is raised while the interrupt enable is set and either flag is set.

Software reaches everything through an 8-bit register port with a 4-bit address. The port takes one write strobe and one read strobe, and read data is registered one cycle after the read strobe. Each compare value is loaded in two byte writes, high byte first. The high-byte write suspends matching on that channel until the low byte arrives. Software can also force a channel latch to a level at once. This force action sets no flag and raises no interrupt, and it is ignored while the alternate-mode input is high.

Top module: `oc_dual_timer`

## Requirements
- R1: After reset the counter holds 0xFFFC, both compare values read 0x00, configuration, level and status read 0x00, both compare channels are disarmed, pins pass `gpio_in`, `irq` is 0 and `rdata` is 0.
- R2: The counter advances by one on each prescaler tick. Configuration bits [2:1] select the period: 00 gives 4 clocks, 01 gives 2 clocks, 10 and 11 give 8 clocks. Address 7 reads counter bits [15:8] and address 8 reads bits [7:0].
- R3: When the counter steps onto an armed channel's compare value, that channel's status flag is set and its latch takes the level bit held at that time, both on the same clock edge as the counter step. Level bit 0 belongs to channel 1 and level bit 1 to channel 2, at address 1. Status bit 0 is flag 1 and status bit 1 is flag 2, at address 2.
- R4: A write to a compare high byte disarms that channel until its low byte is written. No match occurs meanwhile. Channel 1 uses high byte at address 3 and low byte at address 4. Channel 2 uses addresses 5 and 6. A low-byte write arms the channel.
- R5: Configuration bit 3 enables pin 1 and bit 4 enables pin 2. With the enable clear, the pin shows `gpio_in` for that channel, and a match still sets the flag and the interrupt.
- R6: A write to address 1 with bit 2 (channel 1) or bit 3 (channel 2) set loads the written level bit into that latch at once. It sets no flag, and bits 3:2 read back as 0.
- R7: While `mode_alt` is high, force bits have no effect. The level bits are still stored.
- R8: `irq` is high exactly when configuration bit 0 is set and at least one status flag is set.
- R9: A flag is cleared only by a read of status (address 2) while it is set, followed by a write to that channel's low byte. A low-byte write without the prior read leaves the flag set.
- R10: A read strobe returns the addressed register on `rdata` one clock later. Address 0 is configuration, and all 8 written bits read back. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| mode_alt | input | 1 | Alternate waveform mode active; blocks force |
| gpio_in | input | 2 | General-purpose values shown on disabled pins |
| cmp_pin | output | 2 | Channel pins |
| irq | output | 1 | Shared interrupt request |

## Verification
The hardest states to reach are those where two protocol steps must line up with a moving counter. One case is a flag that was read and then cleared by a low-byte write. Another is a channel disarmed by a lone high-byte write while the counter runs past its old target. The stimulus builds targets from the counter value that the bench model currently holds, so every match lands a known few ticks ahead. The bench then runs the read-then-write clear sequence, the write-only sequence that must not clear, and the high-byte-only sequence that must not match. A behavioural model tracks pins, interrupt and read data on every clock.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int DW  = 8;
  localparam int AW  = 4;
  localparam int NCH = 2;
  localparam int CW  = 2 * DW;

  localparam logic [AW-1:0] A_CFG  = 4'd0;
  localparam logic [AW-1:0] A_LVL  = 4'd1;
  localparam logic [AW-1:0] A_STAT = 4'd2;
  localparam logic [AW-1:0] A_C1H  = 4'd3;
  localparam logic [AW-1:0] A_C1L  = 4'd4;
  localparam logic [AW-1:0] A_C2H  = 4'd5;
  localparam logic [AW-1:0] A_C2L  = 4'd6;
  localparam logic [AW-1:0] A_CNTH = 4'd7;
  localparam logic [AW-1:0] A_CNTL = 4'd8;

  typedef enum logic [1:0] {
    DIV4  = 2'b00,
    DIV2  = 2'b01,
    DIV8  = 2'b10,
    DIV8B = 2'b11
  } div_sel_e;
endpackage

// File: rtl/oc_prescaler.sv
module oc_prescaler #(
  parameter int PW = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);
  import oc_pkg::*;

  logic [PW-1:0] pre_q, pre_d, lim;

  always_comb begin
    case (div_sel_e'(sel))
      DIV4:    lim = PW'(3);
      DIV2:    lim = PW'(1);
      default: lim = PW'(7);
    endcase
  end

  assign tick = (pre_q >= lim);

  always_comb begin
    pre_d = tick ? '0 : pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/oc_counter.sv
module oc_counter #(
  parameter int          CW      = 16,
  parameter logic [15:0] RST_VAL = 16'hFFFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign cnt_nxt = cnt_q + CW'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          hi_we,
  input  logic          lo_we,
  input  logic [DW-1:0] wdata,
  input  logic          lvl,
  input  logic          frc,
  input  logic          frc_lvl,
  input  logic          stat_rd,
  output logic [CW-1:0] cmp,
  output logic          flag,
  output logic          pin_lat
);
  logic [CW-1:0] cmp_q, cmp_d;
  logic armed_q, armed_d, flag_q, flag_d, seen_q, seen_d, lat_q, lat_d;
  logic hit;

  assign hit = tick && armed_q && (cnt_nxt == cmp_q);

  always_comb begin
    cmp_d   = cmp_q;
    armed_d = armed_q;
    flag_d  = flag_q;
    seen_d  = seen_q;
    lat_d   = lat_q;
    if (hi_we) begin
      cmp_d[CW-1:DW] = wdata;
      armed_d        = 1'b0;
    end
    if (lo_we) begin
      cmp_d[DW-1:0] = wdata;
      armed_d       = 1'b1;
      if (seen_q) begin
        flag_d = 1'b0;
        seen_d = 1'b0;
      end
    end
    if (stat_rd && flag_q) seen_d = 1'b1;
    if (hit) begin
      flag_d = 1'b1;
      lat_d  = lvl;
    end
    if (frc) lat_d = frc_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
      seen_q  <= 1'b0;
      lat_q   <= 1'b0;
    end else begin
      cmp_q   <= cmp_d;
      armed_q <= armed_d;
      flag_q  <= flag_d;
      seen_q  <= seen_d;
      lat_q   <= lat_d;
    end
  end

  assign cmp     = cmp_q;
  assign flag    = flag_q;
  assign pin_lat = lat_q;

  // R4
  no_disarm_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !$rose(flag_q));

  // R6
  force_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frc && !hit) |=> !$rose(flag_q));

  // R3
  match_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !frc) |=> (lat_q == $past(lvl)) && flag_q);

  // R9
  clear_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !seen_q) |=> flag_q);
endmodule

// File: rtl/oc_regfile.sv
module oc_regfile (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [oc_pkg::AW-1:0]              addr,
  input  logic                               wr_en,
  input  logic                               rd_en,
  input  logic [oc_pkg::DW-1:0]              wdata,
  input  logic                               mode_alt,
  input  logic [oc_pkg::CW-1:0]              cnt,
  input  logic [oc_pkg::NCH-1:0][oc_pkg::CW-1:0] cmp,
  input  logic [oc_pkg::NCH-1:0]             flags,
  output logic                               ie,
  output logic [1:0]                         sel,
  output logic [oc_pkg::NCH-1:0]             oen,
  output logic [oc_pkg::NCH-1:0]             lvl,
  output logic [oc_pkg::NCH-1:0]             hi_we,
  output logic [oc_pkg::NCH-1:0]             lo_we,
  output logic [oc_pkg::NCH-1:0]             frc,
  output logic [oc_pkg::NCH-1:0]             frc_lvl,
  output logic                               stat_rd,
  output logic [oc_pkg::DW-1:0]              rdata
);
  import oc_pkg::*;

  logic [DW-1:0]  cfg_q, cfg_d;
  logic [NCH-1:0] lvl_q, lvl_d;
  logic [DW-1:0]  rd_q, rd_d, rd_mux;

  always_comb begin
    cfg_d   = cfg_q;
    lvl_d   = lvl_q;
    hi_we   = '0;
    lo_we   = '0;
    frc     = '0;
    frc_lvl = wdata[NCH-1:0];
    if (wr_en) begin
      case (addr)
        A_CFG: cfg_d = wdata;
        A_LVL: begin
          lvl_d = wdata[NCH-1:0];
          if (!mode_alt) frc = wdata[2*NCH-1:NCH];
        end
        A_C1H: hi_we[0] = 1'b1;
        A_C1L: lo_we[0] = 1'b1;
        A_C2H: hi_we[1] = 1'b1;
        A_C2L: lo_we[1] = 1'b1;
        default: ;
      endcase
    end
  end

  assign stat_rd = rd_en && (addr == A_STAT);

  always_comb begin
    case (addr)
      A_CFG:   rd_mux = cfg_q;
      A_LVL:   rd_mux = DW'(lvl_q);
      A_STAT:  rd_mux = DW'(flags);
      A_C1H:   rd_mux = cmp[0][CW-1:DW];
      A_C1L:   rd_mux = cmp[0][DW-1:0];
      A_C2H:   rd_mux = cmp[1][CW-1:DW];
      A_C2L:   rd_mux = cmp[1][DW-1:0];
      A_CNTH:  rd_mux = cnt[CW-1:DW];
      A_CNTL:  rd_mux = cnt[DW-1:0];
      default: rd_mux = '0;
    endcase
    rd_d = rd_en ? rd_mux : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      lvl_q <= '0;
      rd_q  <= '0;
    end else begin
      cfg_q <= cfg_d;
      lvl_q <= lvl_d;
      rd_q  <= rd_d;
    end
  end

  assign ie    = cfg_q[0];
  assign sel   = cfg_q[2:1];
  assign oen   = cfg_q[4:3];
  assign lvl   = lvl_q;
  assign rdata = rd_q;

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/oc_dual_timer.sv
module oc_dual_timer #(
  parameter logic [15:0] CNT_RST = 16'hFFFC,
  parameter int          PRE_W   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       mode_alt,
  input  logic [1:0] gpio_in,
  output logic [1:0] cmp_pin,
  output logic       irq
);
  import oc_pkg::*;

  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic                    tick, ie;
  logic [1:0]              sel;
  logic [CW-1:0]           cnt, cnt_nxt;
  logic [NCH-1:0][CW-1:0]  cmp;
  logic [NCH-1:0]          flags, oen, lvl, hi_we, lo_we, frc, frc_lvl, lat;
  logic                    stat_rd;

  oc_prescaler #(.PW(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_i_n), .sel(sel), .tick(tick)
  );

  oc_counter #(.CW(CW), .RST_VAL(CNT_RST)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .cnt(cnt), .cnt_nxt(cnt_nxt)
  );

  oc_regfile u_regs (
    .clk(clk), .rst_n(rst_i_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .mode_alt(mode_alt), .cnt(cnt), .cmp(cmp), .flags(flags),
    .ie(ie), .sel(sel), .oen(oen), .lvl(lvl), .hi_we(hi_we), .lo_we(lo_we),
    .frc(frc), .frc_lvl(frc_lvl), .stat_rd(stat_rd), .rdata(rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    oc_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_i_n), .tick(tick), .cnt_nxt(cnt_nxt),
      .hi_we(hi_we[i]), .lo_we(lo_we[i]), .wdata(wdata), .lvl(lvl[i]),
      .frc(frc[i]), .frc_lvl(frc_lvl[i]), .stat_rd(stat_rd),
      .cmp(cmp[i]), .flag(flags[i]), .pin_lat(lat[i])
    );
    assign cmp_pin[i] = oen[i] ? lat[i] : gpio_in[i];
  end

  assign irq = ie && (|flags);

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |-> (|flags));

  // R7
  mode_force_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode_alt && wr_en && addr == A_LVL && !tick) |=> $stable(lat));
endmodule

// File: tb/sim_oc_dual_timer.sv
module sim_oc_dual_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic       wr_en, rd_en, mode_alt;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [1:0] gpio_in, cmp_pin;
  logic       irq;

  always #2 clk = ~clk;

  oc_dual_timer u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .mode_alt(mode_alt), .gpio_in(gpio_in),
    .cmp_pin(cmp_pin), .irq(irq)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_r1, m_r2, m_pre, m_cnt, m_cfg, m_lvl, m_rd;
  int m_cmp[2], m_arm[2], m_flag[2], m_seen[2], m_lat[2];

  function automatic int m_read(int a);
    case (a)
      0: return m_cfg;
      1: return m_lvl;
      2: return m_flag[0] | (m_flag[1] << 1);
      3: return m_cmp[0] >> 8;
      4: return m_cmp[0] & 255;
      5: return m_cmp[1] >> 8;
      6: return m_cmp[1] & 255;
      7: return m_cnt >> 8;
      8: return m_cnt & 255;
      default: return 0;
    endcase
  endfunction

  task automatic m_reset();
    m_pre = 0; m_cnt = 'hFFFC; m_cfg = 0; m_lvl = 0; m_rd = 0;
    for (int i = 0; i < 2; i++) begin
      m_cmp[i] = 0; m_arm[i] = 0; m_flag[i] = 0; m_seen[i] = 0; m_lat[i] = 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_reset();
    end else if (m_r2 == 0) begin
      m_reset(); m_r2 = m_r1; m_r1 = 1;
    end else begin
      int per, tk, nc, a, rdv;
      int ncfg, nlvl;
      int ncmp[2], narm[2], nflag[2], nseen[2], nlat[2];
      a = int'(addr);
      case ((m_cfg >> 1) & 3) 0: per = 4; 1: per = 2; default: per = 8; endcase
      tk = (m_pre >= per - 1);
      nc = (m_cnt + 1) & 'hFFFF;
      rdv = m_read(a);
      ncfg = m_cfg; nlvl = m_lvl;
      for (int i = 0; i < 2; i++) begin
        ncmp[i] = m_cmp[i]; narm[i] = m_arm[i]; nflag[i] = m_flag[i];
        nseen[i] = m_seen[i]; nlat[i] = m_lat[i];
        if (wr_en && a == 3 + 2*i) begin
          ncmp[i] = (m_cmp[i] & 255) | (int'(wdata) << 8); narm[i] = 0;
        end
        if (wr_en && a == 4 + 2*i) begin
          ncmp[i] = (m_cmp[i] & 'hFF00) | int'(wdata); narm[i] = 1;
          if (m_seen[i]) begin nflag[i] = 0; nseen[i] = 0; end
        end
        if (rd_en && a == 2 && m_flag[i]) nseen[i] = 1;
        if (tk && m_arm[i] && nc == m_cmp[i]) begin
          nflag[i] = 1; nlat[i] = (m_lvl >> i) & 1;
        end
        if (wr_en && a == 1 && !mode_alt && wdata[2+i]) nlat[i] = wdata[i];
      end
      if (wr_en && a == 0) ncfg = int'(wdata);
      if (wr_en && a == 1) nlvl = int'(wdata) & 3;
      if (rd_en) m_rd = rdv;
      m_pre = tk ? 0 : m_pre + 1;
      if (tk) m_cnt = nc;
      m_cfg = ncfg; m_lvl = nlvl;
      for (int i = 0; i < 2; i++) begin
        m_cmp[i] = ncmp[i]; m_arm[i] = narm[i]; m_flag[i] = nflag[i];
        m_seen[i] = nseen[i]; m_lat[i] = nlat[i];
      end
    end
  end

  // every-clock comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < 2; i++) begin
        int ep;
        ep = ((m_cfg >> (3 + i)) & 1) ? m_lat[i] : int'(gpio_in[i]);
        chk("R3/R5 pin", int'(cmp_pin[i]), ep);
      end
      chk("R8 irq", int'(irq), (m_cfg & 1) && (m_flag[0] || m_flag[1]));
      chk("R10 rdata", int'(rdata), m_rd);
    end
  end

  task automatic wr(int a, int d);
    addr = 4'(a); wdata = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    addr = 4'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rdata);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pin(int ch, int val, int lim);
    for (int k = 0; k < lim; k++) begin
      if (int'(cmp_pin[ch]) == val) break;
      @(negedge clk);
    end
  endtask

  task automatic set_cmp(int ch, int v);
    wr(3 + 2*ch, (v >> 8) & 255);
    wr(4 + 2*ch, v & 255);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, a, b, t;
    rst_n = 1'b0; addr = '0; wr_en = 0; rd_en = 0; wdata = '0;
    mode_alt = 0; gpio_in = 2'b10;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R1 reset state
    rd(2, v); chk("R1 status", v, 0);
    rd(4, v); chk("R1 cmp1 lo", v, 0);
    rd(5, v); chk("R1 cmp2 hi", v, 0);
    rd(0, v); chk("R1 cfg", v, 0);
    rd(7, v); chk("R1 cnt hi", v, 'hFF);
    chk("R1 pins", int'(cmp_pin), 2);
    chk("R1 irq", int'(irq), 0);
    rd(12, v); chk("R10 unused addr", v, 0);

    // R2 prescaler periods
    for (int s = 0; s < 4; s++) begin
      int ex;
      wr(0, s << 1);
      idle(10);
      rd(8, a); idle(39); rd(8, b);
      ex = (s == 0) ? 10 : (s == 1) ? 20 : 5;
      chk("R2 ticks", (b - a) & 255, ex);
    end

    // R10 cfg readback, then enable everything, /2
    wr(0, 8'hFB); rd(0, v); chk("R10 cfg readback", v, 'hFB);
    wr(0, 8'h1B);

    // R3 match on channel 1
    wr(1, 1);
    t = (m_cnt + 12) & 'hFFFF;
    set_cmp(0, t);
    wait_pin(0, 1, 80);
    chk("R3 pin1 after match", int'(cmp_pin[0]), 1);
    chk("R8 irq after match", int'(irq), 1);

    // R9 low write without read leaves the flag
    wr(4, t & 255);
    idle(1);
    chk("R9 no clear without read", int'(irq), 1);
    rd(2, v); chk("R3 status flag1", v, 1);
    wr(4, t & 255);
    rd(2, v); chk("R9 cleared", v, 0);
    chk("R9 irq low", int'(irq), 0);
    chk("R9 pin kept", int'(cmp_pin[0]), 1);

    // R6 force
    wr(1, 8'h04);
    chk("R6 forced low", int'(cmp_pin[0]), 0);
    rd(2, v); chk("R6 no flag", v, 0);
    rd(1, v); chk("R6 force reads 0", v, 0);

    // R7 force ignored in alternate mode
    mode_alt = 1;
    wr(1, 8'h05);
    chk("R7 pin held", int'(cmp_pin[0]), 0);
    rd(1, v); chk("R7 level stored", v, 1);
    mode_alt = 0;

    // R4 high write disarms channel 2
    wr(1, 8'h03);
    t = (m_cnt + 30) & 'hFFFF;
    set_cmp(1, t);
    wr(5, (t >> 8) & 255);
    idle(90);
    rd(2, v); chk("R4 no match disarmed", v & 2, 0);
    chk("R4 pin2 idle", int'(cmp_pin[1]), 0);
    t = (m_cnt + 10) & 'hFFFF;
    set_cmp(1, t);
    wait_pin(1, 1, 60);
    chk("R3 pin2 after match", int'(cmp_pin[1]), 1);
    rd(2, v); chk("R3 flag2", v & 2, 2);

    // R5 disabled pin shows gpio, match still flags
    wr(0, 8'h0B);
    gpio_in = 2'b00;
    idle(1);
    chk("R5 pin2 gpio", int'(cmp_pin[1]), 0);
    rd(2, v);
    t = (m_cnt + 10) & 'hFFFF;
    set_cmp(1, t);
    rd(2, v); chk("R9 flag2 cleared", v & 2, 0);
    idle(40);
    rd(2, v); chk("R5 flag while disabled", v & 2, 2);
    chk("R5 pin2 still gpio", int'(cmp_pin[1]), 0);
    chk("R5 irq while disabled", int'(irq), 1);
    gpio_in = 2'b01;
    idle(1);
    chk("R5 pin2 follows gpio", int'(cmp_pin[1]), 0);
    chk("R5 pin1 enabled latch", int'(cmp_pin[0]), 0);

    // R8 interrupt enable off masks
    wr(0, 8'h0A);
    idle(1);
    chk("R8 masked", int'(irq), 0);

    idle(5);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule